// File: doc/BRIEF.md
# Boot Record Write Engine

This block turns a stream of boot bytes into register and memory writes. A receiver outside the block delivers one byte at a time over a valid/ready handshake. The engine groups the bytes into three-byte records: the upper half of a 16-bit address, then the lower half, then a data byte. Each complete record produces exactly one write. The top address bit selects the target. When it is clear, the write goes to memory. When it is set, the write goes to the internal peripheral-register space, and the address is presented with that bit cleared.

Every accepted byte also produces a one-cycle watchdog restart pulse, so a steady boot stream keeps the system watchdog from expiring. The engine only runs while the 2-bit source-select input is nonzero and no terminate request has been seen. It stops at once if the selector returns to zero, and any partly received record is thrown away. One particular peripheral write ends the boot for good, until the next reset: the write to the port-control register at peripheral address 0x0024 with data bit 7 set. The byte sequence 0x80, 0x24, 0x80 is therefore the shutdown command.

Top module: `bootw_engine`

## Requirements
- R1: Bytes are taken as address[15:8], then address[7:0], then data. The write for a record appears on the outputs in the cycle after the clock edge that accepts its third byte, carrying that address and data.
- R2: Address bit 15 = 0 gives a one-cycle `mem_we`. Bit 15 = 1 gives a one-cycle `per_we`, with `wr_addr[15]` driven 0. The two strobes are never high together.
- R3: `in_ready` is low in the cycle the write strobe is high, and high again in the following cycle while the engine is running. Each strobe lasts exactly one cycle.
- R4: `wd_hit` is high for exactly one cycle, in the cycle after each accepted byte, and at no other time.
- R5: A peripheral write to address 0x0024 with data bit 7 = 1 sets `boot_done`, which is high in the strobe cycle itself. From then on `in_ready` stays low. A peripheral write to 0x0024 with bit 7 = 0 does not terminate. A memory write to 0x0024 does not terminate. A peripheral write to any other address does not terminate.
- R6: While `boot_mode` is 00, `in_ready` is low. A partly received record is discarded, and the next byte accepted after the mode becomes nonzero is an address-high byte.
- R7: `boot_done` stays high, whatever `boot_mode` does, until `rst`. After reset, `boot_done`, `wd_hit`, `mem_we` and `per_we` are low.
- R8: The selector values 01, 10 and 11 all run the same record parser and give identical writes.
- R9: `boot_active` equals (`boot_mode` != 00) and not `boot_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 2 | Boot source select; 00 disables the engine |
| in_valid | input | 1 | Byte available from the receiver |
| in_data | input | 8 | Byte value |
| in_ready | output | 1 | Engine can take a byte this cycle |
| wd_hit | output | 1 | Watchdog restart pulse, one per byte |
| wr_addr | output | 16 | Write address (bit 15 cleared) |
| wr_data | output | 8 | Write data |
| mem_we | output | 1 | One-cycle memory write strobe |
| per_we | output | 1 | One-cycle peripheral write strobe |
| boot_active | output | 1 | Engine is running |
| boot_done | output | 1 | Boot ended by the terminate write |

## Verification
The hardest case to reach is the discard of a partial record. The selector has to drop to 00 exactly between the second and third byte of a record, and the next byte must then be shown to start a new address. The stimulus sends two bytes, clears the selector, waits, restores it, and sends a fresh record. If the stale bytes were kept, the write address would be wrong. The near-miss terminate records (wrong bit 7, memory space, neighbouring address) are sent before the real terminate record, and the sweep runs every nonzero selector over a computed set of addresses.

// File: rtl/bootw_pkg.sv
package bootw_pkg;
  typedef enum logic [1:0] {
    PH_AHI  = 2'd0,
    PH_ALO  = 2'd1,
    PH_DAT  = 2'd2,
    PH_WAIT = 2'd3
  } bootw_phase_e;
endpackage

// File: rtl/bootw_framer.sv
module bootw_framer
  import bootw_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              accept,
  output logic              rec_fire,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [DATA_W-1:0] rec_data
);
  bootw_phase_e      phase_q;
  logic [DATA_W-1:0] hi_q, lo_q;

  assign in_ready = run && (phase_q != PH_WAIT);
  assign accept   = in_valid && in_ready;
  assign rec_fire = accept && (phase_q == PH_DAT);
  assign rec_addr = {hi_q, lo_q};
  assign rec_data = in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_AHI;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (!run) begin
      phase_q <= PH_AHI;
    end else begin
      unique case (phase_q)
        PH_AHI: if (accept) begin hi_q <= in_data; phase_q <= PH_ALO; end
        PH_ALO: if (accept) begin lo_q <= in_data; phase_q <= PH_DAT; end
        PH_DAT: if (accept) phase_q <= PH_WAIT;
        default: phase_q <= PH_AHI;
      endcase
    end
  end
endmodule

// File: rtl/bootw_issue.sv
module bootw_issue #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int unsigned TERM_ADDR = 'h24,
  parameter int          TERM_BIT  = 7,
  localparam int         SEL_BIT   = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_fire,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [DATA_W-1:0] rec_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mem_we,
  output logic              per_we,
  output logic              term_hit
);
  logic to_per;
  assign to_per   = rec_addr[SEL_BIT];
  assign term_hit = rec_fire && to_per &&
                    (rec_addr[SEL_BIT-1:0] == SEL_BIT'(TERM_ADDR)) &&
                    rec_data[TERM_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      wr_data <= '0;
      mem_we  <= 1'b0;
      per_we  <= 1'b0;
    end else begin
      mem_we <= rec_fire && !to_per;
      per_we <= rec_fire && to_per;
      if (rec_fire) begin
        wr_addr <= {1'b0, rec_addr[SEL_BIT-1:0]};
        wr_data <= rec_data;
      end
    end
  end
endmodule

// File: rtl/bootw_gate.sv
module bootw_gate #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] boot_mode,
  input  logic              accept,
  input  logic              term_hit,
  output logic              run,
  output logic              wd_hit,
  output logic              boot_done
);
  logic term_q;

  assign run       = (|boot_mode) && !term_q;
  assign boot_done = term_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      term_q <= 1'b0;
      wd_hit <= 1'b0;
    end else begin
      term_q <= term_q || term_hit;
      wd_hit <= accept;
    end
  end
endmodule

// File: rtl/bootw_engine.sv
module bootw_engine #(
  parameter int          DATA_W    = 8,
  parameter int          MODE_W    = 2,
  parameter int unsigned TERM_ADDR = 'h24,
  parameter int          TERM_BIT  = 7,
  localparam int         ADDR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] boot_mode,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              wd_hit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mem_we,
  output logic              per_we,
  output logic              boot_active,
  output logic              boot_done
);
  logic              run, accept, rec_fire, term_hit;
  logic [ADDR_W-1:0] rec_addr;
  logic [DATA_W-1:0] rec_data;

  assign boot_active = run;

  bootw_gate #(.MODE_W(MODE_W)) u_gate (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .accept(accept),
    .term_hit(term_hit), .run(run), .wd_hit(wd_hit), .boot_done(boot_done)
  );

  bootw_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst(rst), .run(run), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .accept(accept), .rec_fire(rec_fire),
    .rec_addr(rec_addr), .rec_data(rec_data)
  );

  bootw_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TERM_ADDR(TERM_ADDR),
                .TERM_BIT(TERM_BIT)) u_issue (
    .clk(clk), .rst(rst), .rec_fire(rec_fire), .rec_addr(rec_addr),
    .rec_data(rec_data), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_we(mem_we), .per_we(per_we), .term_hit(term_hit)
  );
endmodule

// File: rtl/bootw_engine_chk.sv
module bootw_engine_chk #(
  parameter int MODE_W = 2,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] boot_mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic              wd_hit,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              mem_we,
  input logic              per_we,
  input logic              boot_active,
  input logic              boot_done
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && per_we)); // R2
  AST_PER_ADDR_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    per_we |-> !wr_addr[ADDR_W-1]); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mem_we || per_we) |=> !(mem_we || per_we)); // R3
  AST_READY_LOW_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_we || per_we) |-> !in_ready); // R3
  AST_HIT_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> wd_hit); // R4
  AST_HIT_ONLY_BYTE: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !wd_hit); // R4
  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    boot_done |-> !in_ready); // R5
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (boot_mode == '0) |-> !in_ready); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> boot_done); // R7
  AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (rst)
    boot_active == ((boot_mode != '0) && !boot_done)); // R9
endmodule

bind bootw_engine bootw_engine_chk #(.MODE_W(MODE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .boot_mode(boot_mode), .in_valid(in_valid),
  .in_ready(in_ready), .wd_hit(wd_hit), .wr_addr(wr_addr), .mem_we(mem_we),
  .per_we(per_we), .boot_active(boot_active), .boot_done(boot_done)
);

// File: tb/tb_bootw_engine.sv
`timescale 1ns/1ps
module tb_bootw_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  boot_mode = 2'b00;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, wd_hit, mem_we, per_we, boot_active, boot_done;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int failures = 0;
  int hits_seen = 0;
  int bytes_sent = 0;

  always #4 clk = ~clk;

  bootw_engine dut (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .wd_hit(wd_hit),
    .wr_addr(wr_addr), .wr_data(wr_data), .mem_we(mem_we), .per_we(per_we),
    .boot_active(boot_active), .boot_done(boot_done)
  );

  always @(negedge clk) if (!rst && wd_hit) hits_seen++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at negedge, wait for acceptance, return at the negedge after it.
  task automatic send_byte(input logic [7:0] b);
    bit done_b = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!done_b) begin
      #1;
      if (in_ready) done_b = 1;
      @(posedge clk);
      @(negedge clk);
    end
    bytes_sent++;
    chk(wd_hit == 1'b1, "R4 hit after byte", wd_hit, 1);
    in_valid = 1'b0;
  endtask

  task automatic send_rec(input logic [15:0] a, input logic [7:0] d);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    send_byte(d);
  endtask

  task automatic expect_write(input logic [15:0] a, input logic [7:0] d,
                              input string req);
    chk(mem_we == !a[15], {req, " mem_we"}, mem_we, !a[15]);
    chk(per_we == a[15], {req, " per_we"}, per_we, a[15]);
    chk(wr_addr == {1'b0, a[14:0]}, {req, " addr"}, wr_addr, {1'b0, a[14:0]});
    chk(wr_data == d, {req, " data"}, wr_data, d);
    chk(in_ready == 1'b0, "R3 ready low on strobe", in_ready, 0);
    @(negedge clk);
    chk(!mem_we && !per_we, "R3 strobe one cycle", {mem_we, per_we}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R7 reset state
    chk(!boot_done && !mem_we && !per_we && !wd_hit, "R7 reset outputs",
        {boot_done, mem_we, per_we, wd_hit}, 0);
    chk(in_ready == 1'b0, "R6 ready low mode 00", in_ready, 0);
    chk(boot_active == 1'b0, "R9 inactive mode 00", boot_active, 0);

    // R1/R2/R8 sweep over the three source selects
    for (int m = 1; m < 4; m++) begin
      @(negedge clk);
      boot_mode = 2'(m);
      #1;
      chk(boot_active == 1'b1, "R9 active", boot_active, 1);
      chk(in_ready == 1'b1, "R8 ready in mode", in_ready, 1);
      for (int i = 0; i < 40; i++) begin
        a = 16'(i * 16'h2F1B + m * 16'h0457) ^ {i[0], 15'h0};
        d = 8'(i * 37 + m);
        if (a == 16'h8024) d[7] = 1'b0;
        send_rec(a, d);
        expect_write(a, d, "R1 R2 R8 sweep");
        chk(in_ready == 1'b1, "R3 ready after strobe", in_ready, 1);
      end
    end

    // R4 byte/hit accounting
    chk(hits_seen == bytes_sent, "R4 hit count", hits_seen, bytes_sent);

    // R6 partial record discard
    send_byte(8'hAB);
    send_byte(8'hCD);
    @(negedge clk);
    boot_mode = 2'b00;
    #1;
    chk(in_ready == 1'b0, "R6 ready low mode 00", in_ready, 0);
    chk(boot_active == 1'b0, "R9 inactive", boot_active, 0);
    repeat (3) @(negedge clk);
    boot_mode = 2'b10;
    send_rec(16'h1234, 8'h56);
    expect_write(16'h1234, 8'h56, "R6 fresh record");

    // R5 near misses
    send_rec(16'h8024, 8'h7F);
    chk(boot_done == 1'b0, "R5 bit7 clear", boot_done, 0);
    expect_write(16'h8024, 8'h7F, "R5 per bit7 clear");
    send_rec(16'h0024, 8'h80);
    chk(boot_done == 1'b0, "R5 memory space", boot_done, 0);
    expect_write(16'h0024, 8'h80, "R5 mem write");
    send_rec(16'h8025, 8'hFF);
    chk(boot_done == 1'b0, "R5 other address", boot_done, 0);
    expect_write(16'h8025, 8'hFF, "R5 per other");

    // R5 terminate
    send_rec(16'h8024, 8'h80);
    chk(boot_done == 1'b1, "R5 done in strobe cycle", boot_done, 1);
    chk(per_we == 1'b1 && wr_addr == 16'h0024, "R5 terminate write",
        {per_we, wr_addr}, {1'b1, 16'h0024});
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      boot_mode = 2'(k % 4);
      in_valid  = 1'b1;
      #1;
      chk(in_ready == 1'b0, "R5 ready held low", in_ready, 0);
      chk(boot_done == 1'b1, "R7 done sticky", boot_done, 1);
      chk(boot_active == 1'b0, "R9 inactive after done", boot_active, 0);
    end
    @(negedge clk);
    chk(!mem_we && !per_we && !wd_hit, "R5 no activity after done",
        {mem_we, per_we, wd_hit}, 0);
    in_valid = 1'b0;

    // R7 reset clears done
    rst = 1'b1;
    boot_mode = 2'b11;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(boot_done == 1'b0, "R7 done cleared by reset", boot_done, 0);
    chk(in_ready == 1'b1, "R7 running after reset", in_ready, 1);
    send_rec(16'hFFFF, 8'h01);
    expect_write(16'hFFFF, 8'h01, "R2 top address");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule